// File: doc/BRIEF.md
# Host-to-Peripheral Bus Transfer Sequencer

This block takes single read or write requests from a simple host port and plays each one out on an APB peripheral bus that serves several slaves. The request carries an address, a write flag and write data. The block picks the slave from a field of the address and raises only that slave's select line. It then runs the two-phase transfer: one setup cycle with the enable strobe low, then one access cycle with the strobe high. When the access cycle ends, the block returns a one-cycle completion pulse and, for reads, the captured read data.

A host keeps a request valid until the sequencer accepts it. Acceptance is possible in any cycle except a setup cycle. When a new request is waiting at the end of an access cycle, the bus goes straight into the next setup phase and does not pass through idle, so a steady stream costs two cycles per transfer.

For testing, each select line drives a small register-file slave. Its read port is registered, so the storage maps onto block RAM. The bus signals are brought out so the sequence can be observed.

Top module: `apb_xfer_bridge`

## Requirements
- R1: After synchronous reset the outputs are: all selects low, enable low, completion low, returned read data zero, and request-ready high.
- R2: While no request is pending the bus stays idle: all selects and the enable stay low, and no completion pulse is produced.
- R3: A request accepted while the bus is idle or in an access cycle leads, one cycle later, to a setup cycle. In that setup cycle exactly one select is high, the enable is low, and the address, write flag and write data equal the accepted request.
- R4: A setup cycle lasts exactly one clock. The next cycle raises the enable and leaves the select, address and write flag unchanged. Request-ready is low only during setup cycles.
- R5: The raised select has the index given by address bits [13:12]: value 0 selects line 0, and so on up to value 3, which selects line 3.
- R6: After an access cycle the bus enters a new setup cycle if a request was accepted in that access cycle, and returns to idle otherwise. The enable is never high for two cycles in a row.
- R7: The completion output is high for exactly the one cycle after each access cycle. After a read, the returned read data holds the word read. A write leaves the returned read data unchanged.
- R8: Each slave holds 16 words, indexed by address bits [5:2]. A write stores the data only in the addressed word of the selected slave. Address bits outside [13:12] and [5:2] have no effect.
- R9: A read issued back-to-back right after a write to the same word returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Data returned by the last read |
| bus_sel | output | 4 | One-hot slave selects |
| bus_enable | output | 1 | Access-phase strobe |
| bus_addr | output | 16 | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | output | 32 | Read data from the selected slave |

## Verification
The bench targets these failure modes and what each wrong design would show:
- Streams with no idle gaps: a design that passes through idle between transfers, or that accepts a request during setup, would show the extra cycle or the lost request.
- A read right after a write to the same word: a slave that samples its storage too early would return the stale value.
- Addresses with noise in the bits that are not decoded: a decoder that looks at too many bits would pick the wrong slave or the wrong word.
- Reads mixed with writes: a completion pulse that lands one cycle off would show up at once, as would returned data that a write clobbers.

// File: rtl/apb_xb_pkg.sv
package apb_xb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } bus_phase_e;
endpackage

// File: rtl/apb_xb_decode.sv
module apb_xb_decode #(
  parameter int NUM_SLAVES = 4,
  localparam int SEL_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic [SEL_W-1:0]      sel_field,
  output logic [NUM_SLAVES-1:0] sel_onehot
);
  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_line
    assign sel_onehot[i] = (sel_field == SEL_W'(i));
  end
endmodule

// File: rtl/apb_xb_seq.sv
module apb_xb_seq
  import apb_xb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_SLAVES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [NUM_SLAVES-1:0] sel_onehot,
  input  logic [DATA_W-1:0]     prdata,
  output logic                  req_ready,
  output logic [NUM_SLAVES-1:0] psel,
  output logic                  penable,
  output logic [ADDR_W-1:0]     paddr,
  output logic                  pwrite,
  output logic [DATA_W-1:0]     pwdata,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata
);
  bus_phase_e phase_q;
  logic       take;

  assign req_ready = (phase_q != PH_SETUP);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      psel      <= '0;
      penable   <= 1'b0;
      paddr     <= '0;
      pwrite    <= 1'b0;
      pwdata    <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_ACCESS;
          penable <= 1'b1;
        end
        PH_ACCESS: begin
          rsp_done <= 1'b1;
          if (!pwrite) rsp_rdata <= prdata;
          penable <= 1'b0;
          if (take) begin
            phase_q <= PH_SETUP;
            psel    <= sel_onehot;
            paddr   <= req_addr;
            pwrite  <= req_write;
            pwdata  <= req_wdata;
          end else begin
            phase_q <= PH_IDLE;
            psel    <= '0;
          end
        end
        default: begin
          if (take) begin
            phase_q <= PH_SETUP;
            psel    <= sel_onehot;
            paddr   <= req_addr;
            pwrite  <= req_write;
            pwdata  <= req_wdata;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/apb_xb_regslave.sv
module apb_xb_regslave #(
  parameter int DATA_W = 32,
  parameter int REGS   = 16,
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [REGS];

  // Write at end of access cycle; registered read sampled at end of setup.
  always_ff @(posedge clk) begin
    if (sel && enable && write) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (sel && !enable && !write) rdata <= mem[idx];
  end
endmodule

// File: rtl/apb_xb_rdmux.sv
module apb_xb_rdmux #(
  parameter int DATA_W     = 32,
  parameter int NUM_SLAVES = 4
) (
  input  logic [NUM_SLAVES-1:0]             sel,
  input  logic [NUM_SLAVES-1:0][DATA_W-1:0] rd_arr,
  output logic [DATA_W-1:0]                 rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLAVES; i++) begin
      if (sel[i]) rdata = rdata | rd_arr[i];
    end
  end
endmodule

// File: rtl/apb_xfer_bridge.sv
module apb_xfer_bridge #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_SLAVES = 4,
  parameter int SEL_LSB    = 12,
  parameter int REGS       = 16,
  parameter int IDX_LSB    = 2,
  localparam int SEL_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1,
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [NUM_SLAVES-1:0] bus_sel,
  output logic                  bus_enable,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_write,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata
);
  logic [NUM_SLAVES-1:0]             sel_oh;
  logic [NUM_SLAVES-1:0][DATA_W-1:0] rd_arr;

  apb_xb_decode #(.NUM_SLAVES(NUM_SLAVES)) u_dec (
    .sel_field (req_addr[SEL_LSB +: SEL_W]),
    .sel_onehot(sel_oh)
  );

  apb_xb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLAVES(NUM_SLAVES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sel_onehot(sel_oh),
    .prdata    (bus_rdata),
    .req_ready (req_ready),
    .psel      (bus_sel),
    .penable   (bus_enable),
    .paddr     (bus_addr),
    .pwrite    (bus_write),
    .pwdata    (bus_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slave
    apb_xb_regslave #(.DATA_W(DATA_W), .REGS(REGS)) u_rf (
      .clk   (clk),
      .sel   (bus_sel[s]),
      .enable(bus_enable),
      .write (bus_write),
      .idx   (bus_addr[IDX_LSB +: IDX_W]),
      .wdata (bus_wdata),
      .rdata (rd_arr[s])
    );
  end

  apb_xb_rdmux #(.DATA_W(DATA_W), .NUM_SLAVES(NUM_SLAVES)) u_mux (
    .sel   (bus_sel),
    .rd_arr(rd_arr),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/apb_xfer_bridge_chk.sv
module apb_xfer_bridge_chk #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SLAVES = 4,
  parameter int SEL_LSB    = 12,
  localparam int SEL_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  req_ready,
  input logic                  rsp_done,
  input logic [NUM_SLAVES-1:0] bus_sel,
  input logic                  bus_enable,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_write
);
  a_r2_enable_needs_sel: assert property (@(posedge clk) disable iff (rst)
    bus_enable |-> (|bus_sel));

  a_r3_idle_take: assert property (@(posedge clk) disable iff (rst)
    (!(|bus_sel) && req_valid) |=> ((|bus_sel) && !bus_enable && bus_addr == $past(req_addr)));

  a_r4_setup_to_access: assert property (@(posedge clk) disable iff (rst)
    ((|bus_sel) && !bus_enable) |=>
      (bus_enable && $stable(bus_sel) && $stable(bus_addr) && $stable(bus_write)));

  a_r4_not_ready_in_setup: assert property (@(posedge clk) disable iff (rst)
    ((|bus_sel) && !bus_enable) |-> !req_ready);

  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_sel));

  a_r5_sel_matches_addr: assert property (@(posedge clk) disable iff (rst)
    (|bus_sel) |-> bus_sel[bus_addr[SEL_LSB +: SEL_W]]);

  a_r6_access_single: assert property (@(posedge clk) disable iff (rst)
    bus_enable |=> !bus_enable);

  a_r6_chain_to_setup: assert property (@(posedge clk) disable iff (rst)
    (bus_enable && req_valid) |=> ((|bus_sel) && !bus_enable));

  a_r7_done_after_access: assert property (@(posedge clk) disable iff (rst)
    bus_enable |=> rsp_done);

  a_r7_done_only_after_access: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(bus_enable));
endmodule

bind apb_xfer_bridge apb_xfer_bridge_chk #(
  .ADDR_W(ADDR_W), .NUM_SLAVES(NUM_SLAVES), .SEL_LSB(SEL_LSB)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .rsp_done(rsp_done), .bus_sel(bus_sel),
  .bus_enable(bus_enable), .bus_addr(bus_addr), .bus_write(bus_write)
);

// File: tb/tb_apb_xfer_bridge.sv
module tb_apb_xfer_bridge;
  typedef struct {
    bit          w;
    logic [15:0] a;
    logic [31:0] d;
  } req_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_done, bus_enable, bus_write;
  logic [31:0] rsp_rdata, bus_wdata, bus_rdata;
  logic [3:0]  bus_sel;
  logic [15:0] bus_addr;

  apb_xfer_bridge dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_sel(bus_sel),
    .bus_enable(bus_enable), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  req_t pend[$];
  req_t cur;
  bit   have = 0;
  bit   gaps = 1;

  // Reference model state
  int          m_phase = 0, m_prev = 0;
  int          m_sel = 0, m_idx = 0;
  bit          m_write = 0, m_done = 0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0, m_rdata = '0;
  logic [31:0] mem [4][16];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_addr(int s, int i);
    logic [15:0] a;
    a = 16'($urandom);
    a[13:12] = 2'(s);
    a[5:2] = 4'(i);
    return a;
  endfunction

  task automatic compare();
    logic [3:0] esel;
    string pl;
    esel = (m_phase != 0) ? 4'(1 << m_sel) : 4'd0;
    chk(bus_sel === esel, "R5 select decode", 32'(bus_sel), 32'(esel));
    pl = (m_phase == 0) ? "R2 idle enable" :
         (m_phase == 1) ? ((m_prev == 2) ? "R6 chained setup" : "R3 setup enable")
                        : "R4 access enable";
    chk(bus_enable === (m_phase == 2), pl, 32'(bus_enable), 32'(m_phase == 2));
    chk(req_ready === (m_phase != 1), "R4 ready", 32'(req_ready), 32'(m_phase != 1));
    chk(rsp_done === m_done, "R7 done pulse", 32'(rsp_done), 32'(m_done));
    chk(rsp_rdata === m_rdata, "R7 returned data", rsp_rdata, m_rdata);
    if (m_phase != 0) begin
      chk(bus_addr === m_addr, "R3 address", 32'(bus_addr), 32'(m_addr));
      chk(bus_write === m_write, "R3 write flag", 32'(bus_write), 32'(m_write));
      if (m_write) chk(bus_wdata === m_wdata, "R3 write data", bus_wdata, m_wdata);
    end
    if (m_phase == 2 && !m_write)
      chk(bus_rdata === mem[m_sel][m_idx], "R8 slave read", bus_rdata, mem[m_sel][m_idx]);
  endtask

  task automatic step();
    bit take;
    @(negedge clk);
    compare();
    if (!have && pend.size() > 0 && (!gaps || $urandom_range(0, 2) == 0)) begin
      cur = pend.pop_front();
      have = 1;
    end
    req_valid = have;
    req_write = cur.w;
    req_addr  = cur.a;
    req_wdata = cur.d;
    take = have && (m_phase != 1);
    m_prev = m_phase;
    m_done = 0;
    case (m_phase)
      1: m_phase = 2;
      2: begin
        m_done = 1;
        if (m_write) mem[m_sel][m_idx] = m_wdata;
        else m_rdata = mem[m_sel][m_idx];
        m_phase = 0;
      end
      default: ;
    endcase
    if (take) begin
      m_phase = 1;
      m_addr  = cur.a;
      m_sel   = int'(cur.a[13:12]);
      m_idx   = int'(cur.a[5:2]);
      m_write = cur.w;
      m_wdata = cur.d;
      have = 0;
    end
  endtask

  task automatic drain();
    int lim = 0;
    while ((pend.size() > 0 || have || m_phase != 0 || m_done) && lim < 20000) begin
      step();
      lim++;
    end
    if (lim >= 20000) begin
      n_fail++;
      $display("FAIL watchdog: drain stalled, actual %0d expected 0", pend.size());
    end
  endtask

  task automatic push(bit w, logic [15:0] a, logic [31:0] d);
    req_t r;
    r.w = w; r.a = a; r.d = d;
    pend.push_back(r);
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected end");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the first cycle after reset
    @(negedge clk);
    chk(bus_sel === 4'd0, "R1 selects", 32'(bus_sel), 0);
    chk(bus_enable === 1'b0, "R1 enable", 32'(bus_enable), 0);
    chk(rsp_done === 1'b0, "R1 done", 32'(rsp_done), 0);
    chk(rsp_rdata === 32'd0, "R1 read data", rsp_rdata, 0);
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
    // R2: idle with nothing pending
    repeat (5) step();
    // R8: fill every word of every slave, then read all back
    gaps = 1;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 16; i++) push(1, mk_addr(s, i), $urandom);
    drain();
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 16; i++) push(0, mk_addr(s, i), 32'd0);
    drain();
    // R6, R9: gapless stream, each write followed by a read of the same word
    gaps = 0;
    for (int k = 0; k < 40; k++) begin
      int s = $urandom_range(0, 3);
      int i = $urandom_range(0, 15);
      push(1, mk_addr(s, i), $urandom);
      push(0, mk_addr(s, i), 32'd0);
    end
    drain();
    // Mixed traffic, alternating gapless and gapped phases
    for (int blk = 0; blk < 8; blk++) begin
      gaps = blk[0];
      for (int k = 0; k < 80; k++)
        push($urandom_range(0, 1) == 1, mk_addr($urandom_range(0, 3), $urandom_range(0, 15)), $urandom);
      drain();
    end
    repeat (4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule